// File: doc/BRIEF.md
# Capture/Compare Channel with Fractional Dithering

This block is one channel of a timer. An external free-running counter feeds it. In output mode software programs a compare value. The channel then drives a pulse-width output that is high while the counter is below the effective compare value. The value goes either straight into the active compare register or, when buffering is on, into a holding register that is copied across on an update pulse. A dithering option treats the low four bits of the compare value as sixteenths. It lengthens the pulse by one count in that many of every sixteen counter periods, so the average pulse width has fractional resolution.

In input mode the channel latches the counter value on each capture pulse and raises a sticky flag. Software clears the flag by writing one to it. While dithering is on, a captured value has its low four bits cleared. One small register port gives access to the value, the control bits and the flag.

The channel mode is a three-state machine: `CH_OUT_DIRECT` (writes reach the active register at once), `CH_OUT_BUFFERED` (writes wait for an update pulse) and `CH_IN_CAPTURE` (counter latching). Every control-register write is a transition. It goes to `CH_IN_CAPTURE` when the input bit is set. Otherwise it goes to `CH_OUT_BUFFERED` when the preload bit is set, and to `CH_OUT_DIRECT` when neither bit is set. Without a control write the state holds.

Top module: `ccx_channel`

## Requirements
- R1: After reset every register reads zero, the state is `CH_OUT_DIRECT`, the dither period index is 0 and `cmp_o` is low.
- R2: In `CH_OUT_DIRECT` a write to the value register (address 0) loads the holding and active registers at the same clock edge.
- R3: In `CH_OUT_BUFFERED` the active register changes only on an `update_i` pulse, which copies the holding register across. A value write in the same cycle as an update is used at the next update.
- R4: `cmp_o` is registered. After each clock edge it equals (counter < effective compare) as sampled at that edge, so an effective compare of zero keeps it low.
- R5: With dithering off the full 20-bit active value is the effective compare.
- R6: With dithering on, a 4-bit period index k advances on each `cnt_wrap_i` pulse. The effective compare is bits [19:4] plus one when k < bits [3:0], and bits [19:4] otherwise.
- R7: In `CH_IN_CAPTURE` a `capture_i` pulse stores `cnt_i` in the value register, writes to address 0 are ignored, and `cmp_o` stays low.
- R8: A capture taken while dithering is on stores the counter with bits [3:0] cleared.
- R9: The status flag (address 2, bit 0) sets on each capture and clears when a one is written to it. A capture in the same cycle as the clear leaves it set.
- R10: Register map: address 0 holds the value, address 1 holds the control bits (bit 0 input mode, bit 1 preload, bit 2 dither) and address 2 holds the status. Reads are combinational on `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 20 | Timer counter value |
| cnt_wrap_i | input | 1 | One-cycle pulse at each counter wrap |
| update_i | input | 1 | One-cycle update event |
| capture_i | input | 1 | One-cycle capture event |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 20 | Write data |
| rdata_o | output | 20 | Read data |
| cmp_o | output | 1 | Compare output |

## Verification
The hardest condition to reach is a particular dither period paired with a particular fractional value. The period index is internal and moves only on wrap pulses. The bench therefore tracks the wrap count itself from reset. For every one of the sixteen fractions it steps through all sixteen periods, probing the counter just below, at and above the integer part. The same-cycle collisions (a value write against an update, a capture against a flag clear) are produced by driving both strobes in one cycle.

// File: rtl/ccx_pkg.sv
package ccx_pkg;
    typedef enum logic [1:0] {
        CH_OUT_DIRECT   = 2'd0,
        CH_OUT_BUFFERED = 2'd1,
        CH_IN_CAPTURE   = 2'd2
    } ch_state_e;

    localparam logic [1:0] ADDR_VALUE = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;
    localparam logic [1:0] ADDR_STAT  = 2'd2;

    localparam int CTRL_INPUT   = 0;
    localparam int CTRL_PRELOAD = 1;
    localparam int CTRL_DITHER  = 2;
endpackage

// File: rtl/ccx_mode_fsm.sv
module ccx_mode_fsm
    import ccx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ctrl_wr_i,
    input  logic      want_input_i,
    input  logic      want_preload_i,
    output ch_state_e state_o,
    output logic      is_input_o,
    output logic      is_buffered_o
);
    ch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ctrl_wr_i) begin
            unique case ({want_input_i, want_preload_i})
                2'b00:        state_d = CH_OUT_DIRECT;
                2'b01:        state_d = CH_OUT_BUFFERED;
                2'b10, 2'b11: state_d = CH_IN_CAPTURE;
                default:      state_d = CH_OUT_DIRECT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OUT_DIRECT;
        else        state_q <= state_d;
    end

    always_comb begin
        is_input_o    = 1'b0;
        is_buffered_o = 1'b0;
        unique case (state_q)
            CH_OUT_DIRECT:   ;
            CH_OUT_BUFFERED: is_buffered_o = 1'b1;
            CH_IN_CAPTURE:   is_input_o    = 1'b1;
            default:         ;
        endcase
    end

    assign state_o = state_q;

    AST_CTRL_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && want_input_i) |=> (state_q == CH_IN_CAPTURE)); // R10
endmodule

// File: rtl/ccx_dither.sv
module ccx_dither #(
    parameter int CMP_W  = 20,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap_i,
    input  logic             dith_en_i,
    input  logic [CMP_W-1:0] active_i,
    output logic [CMP_W:0]   eff_o
);
    localparam int INT_W = CMP_W - FRAC_W;

    logic [FRAC_W-1:0] period_q;
    logic [INT_W-1:0]  int_part;
    logic [FRAC_W-1:0] frac_part;
    logic              bump;
    logic [INT_W:0]    int_bumped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      period_q <= '0;
        else if (wrap_i) period_q <= period_q + 1'b1;
    end

    assign int_part   = active_i[CMP_W-1:FRAC_W];
    assign frac_part  = active_i[FRAC_W-1:0];
    assign bump       = (period_q < frac_part);
    assign int_bumped = {1'b0, int_part} + {{INT_W{1'b0}}, bump};

    generate
        if (FRAC_W > 0) begin : g_frac
            assign eff_o = dith_en_i ? {{FRAC_W{1'b0}}, int_bumped} : {1'b0, active_i};
        end else begin : g_nofrac
            assign eff_o = {1'b0, active_i};
        end
    endgenerate

    AST_PERIOD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (period_q == $past(period_q) + 1'b1)); // R6
    AST_DITHER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        dith_en_i |-> ((eff_o - {{(FRAC_W+1){1'b0}}, int_part}) <= 1)); // R6
endmodule

// File: rtl/ccx_channel.sv
module ccx_channel
    import ccx_pkg::*;
#(
    parameter int CMP_W  = 20,
    parameter int FRAC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMP_W-1:0] cnt_i,
    input  logic             cnt_wrap_i,
    input  logic             update_i,
    input  logic             capture_i,
    input  logic             wr_en_i,
    input  logic [1:0]       addr_i,
    input  logic [CMP_W-1:0] wdata_i,
    output logic [CMP_W-1:0] rdata_o,
    output logic             cmp_o
);
    ch_state_e        state;
    logic             is_input, is_buffered;
    logic             wr_val, wr_ctrl, wr_stat;
    logic [CMP_W-1:0] shadow_q, active_q, cap_val;
    logic             dith_q, flag_q, cmp_q;
    logic [CMP_W:0]   eff_cmp;

    assign wr_val  = wr_en_i && (addr_i == ADDR_VALUE);
    assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);

    ccx_mode_fsm u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr_i      (wr_ctrl),
        .want_input_i   (wdata_i[CTRL_INPUT]),
        .want_preload_i (wdata_i[CTRL_PRELOAD]),
        .state_o        (state),
        .is_input_o     (is_input),
        .is_buffered_o  (is_buffered)
    );

    ccx_dither #(.CMP_W(CMP_W), .FRAC_W(FRAC_W)) u_dither (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrap_i    (cnt_wrap_i),
        .dith_en_i (dith_q),
        .active_i  (active_q),
        .eff_o     (eff_cmp)
    );

    assign cap_val = dith_q ? {cnt_i[CMP_W-1:FRAC_W], {FRAC_W{1'b0}}} : cnt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (is_input) begin
            if (capture_i) shadow_q <= cap_val;
        end else if (wr_val) begin
            shadow_q <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= '0;
        end else begin
            unique case (state)
                CH_OUT_DIRECT:   if (wr_val)   active_q <= wdata_i;
                CH_OUT_BUFFERED: if (update_i) active_q <= shadow_q;
                CH_IN_CAPTURE:   ;
                default:         ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dith_q <= 1'b0;
            flag_q <= 1'b0;
            cmp_q  <= 1'b0;
        end else begin
            if (wr_ctrl) dith_q <= wdata_i[CTRL_DITHER];
            if (is_input && capture_i)    flag_q <= 1'b1;
            else if (wr_stat && wdata_i[0]) flag_q <= 1'b0;
            cmp_q <= !is_input && ({1'b0, cnt_i} < eff_cmp);
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_VALUE: rdata_o = shadow_q;
            ADDR_CTRL: begin
                rdata_o[CTRL_INPUT]   = is_input;
                rdata_o[CTRL_PRELOAD] = is_buffered;
                rdata_o[CTRL_DITHER]  = dith_q;
            end
            ADDR_STAT: rdata_o[0] = flag_q;
            default:   rdata_o = '0;
        endcase
    end

    assign cmp_o = cmp_q;

    AST_DIRECT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OUT_DIRECT && wr_val) |=> (active_q == $past(wdata_i))); // R2
    AST_BUFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OUT_BUFFERED && !update_i) |=> $stable(active_q)); // R3
    AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IN_CAPTURE) |=> !cmp_o); // R7
    AST_CAP_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IN_CAPTURE && dith_q && capture_i) |=> (shadow_q[FRAC_W-1:0] == '0)); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_IN_CAPTURE && capture_i) |=> flag_q); // R9
    AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_cmp == '0) |=> !cmp_o); // R4
endmodule

// File: tb/ccx_channel_bench.sv
module ccx_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] cnt_i = '0;
    logic        cnt_wrap_i = 1'b0;
    logic        update_i = 1'b0;
    logic        capture_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  addr_i = '0;
    logic [19:0] wdata_i = '0;
    logic [19:0] rdata_o;
    logic        cmp_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ccx_channel u_ccx_channel (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_wrap_i(cnt_wrap_i),
        .update_i(update_i), .capture_i(capture_i), .wr_en_i(wr_en_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .cmp_o(cmp_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [19:0] d);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [19:0] exp, input string req);
        addr_i = a;
        #1;
        check(rdata_o == exp, req, int'(rdata_o), int'(exp));
    endtask

    task automatic cmp_chk(input logic [19:0] c, input logic [20:0] eff, input string req);
        logic expv;
        cnt_i = c;
        tick();
        expv = ({1'b0, c} < eff);
        check(cmp_o == expv, req, int'(cmp_o), int'(expv));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [19:0] vals [5];
        logic [19:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(2'd0, 20'h0, "R1 value");
        rd_chk(2'd1, 20'h0, "R1 ctrl");
        rd_chk(2'd2, 20'h0, "R1 status");
        check(cmp_o == 1'b0, "R1 cmp", int'(cmp_o), 0);

        // R2 R4 R5 direct mode, full-width compare
        vals = '{20'h0, 20'h1, 20'h7, 20'h25, 20'hABCDE};
        foreach (vals[i]) begin
            v = vals[i];
            wr(2'd0, v);
            cmp_chk(20'h0, {1'b0, v}, "R4 zero/low");
            cmp_chk(v - 20'h1, {1'b0, v}, "R2 R5 below");
            cmp_chk(v, {1'b0, v}, "R5 at");
            cmp_chk(v + 20'h1, {1'b0, v}, "R5 above");
        end
        wr(2'd0, 20'h25);

        // R3 buffered
        wr(2'd1, 20'h2);
        rd_chk(2'd1, 20'h2, "R10 ctrl buffered");
        wr(2'd0, 20'd100);
        cmp_chk(20'd50, 21'h25, "R3 held before update");
        rd_chk(2'd0, 20'd100, "R3 holding readback");
        update_i = 1'b1; tick(); update_i = 1'b0;
        cmp_chk(20'd50, 21'd100, "R3 after update");
        update_i = 1'b1; wr(2'd0, 20'd10); update_i = 1'b0;
        cmp_chk(20'd50, 21'd100, "R3 same-cycle write deferred");
        update_i = 1'b1; tick(); update_i = 1'b0;
        cmp_chk(20'd50, 21'd10, "R3 next update");

        // R6 dither sweep: all fractions over all 16 periods
        wr(2'd1, 20'h4);
        rd_chk(2'd1, 20'h4, "R10 ctrl dither");
        for (int f = 0; f < 16; f++) begin
            wr(2'd0, {16'd3, 4'(f)});
            for (int p = 0; p < 16; p++) begin
                logic [20:0] eff;
                eff = 21'd3 + ((p < f) ? 21'd1 : 21'd0);
                cmp_chk(20'd2, eff, "R6 below int");
                cmp_chk(20'd3, eff, "R6 at int");
                cmp_chk(20'd4, eff, "R6 above int");
                cnt_wrap_i = 1'b1; tick(); cnt_wrap_i = 1'b0;
            end
        end
        wr(2'd0, 20'hFFFFF);
        cmp_chk(20'h0FFFF, 21'h10000, "R6 max int carry");
        cmp_chk(20'h10000, 21'h10000, "R6 max int limit");

        // R7 input mode
        wr(2'd1, 20'h1);
        cmp_chk(20'h0, 21'h0, "R7 output low");
        wr(2'd0, 20'd555);
        rd_chk(2'd0, 20'hFFFFF, "R7 write ignored");
        cnt_i = 20'h12345; capture_i = 1'b1; tick(); capture_i = 1'b0;
        rd_chk(2'd0, 20'h12345, "R7 captured");
        rd_chk(2'd2, 20'h1, "R9 flag set");
        wr(2'd2, 20'h0);
        rd_chk(2'd2, 20'h1, "R9 zero write keeps");
        wr(2'd2, 20'h1);
        rd_chk(2'd2, 20'h0, "R9 cleared");
        cnt_i = 20'h00042; capture_i = 1'b1; wr(2'd2, 20'h1); capture_i = 1'b0;
        rd_chk(2'd2, 20'h1, "R9 set wins");
        rd_chk(2'd0, 20'h00042, "R7 second capture");

        // R8 capture with dither
        wr(2'd1, 20'h5);
        rd_chk(2'd1, 20'h5, "R10 ctrl input dither");
        cnt_i = 20'hABCDF; capture_i = 1'b1; tick(); capture_i = 1'b0;
        rd_chk(2'd0, 20'hABCD0, "R8 low bits cleared");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule